// File: doc/BRIEF.md
# Word polarity and balance encoder

This block sits in a front-end transmit path between the frame builder and the serializer. It receives one 18-bit word per clock, with a frame-start marker and a flag saying whether the word's eight-bit payload field (bits 8..1) is a free balance slot. Its job is to keep each frame close to equal numbers of ones and zeros on the line.

It keeps a running disparity: ones minus zeros over every transmitted bit since the frame started. When the incoming word has a free slot, the block writes a filler byte into bits 8..1. The byte opens with a run of identical bits that pushes against the running disparity, and the rest of the byte alternates. Then, for every word, the block decides whether bits 16..1 go out true or inverted. It records that choice in bit 0 and passes bit 17 through unchanged. The encoded word and the frame-start marker come out of one register stage.

Top module: `pbe_encoder`

## Requirements
- R1: While rst_n is low, word_out and out_frame_start are 0.
- R2: Each encoded word and its frame-start marker appear on the outputs exactly one clock after the word is presented, and a word enters on every clock.
- R3: Bit 17 of word_out equals bit 17 of the input word.
- R4: Bit 0 of the input word is ignored. Bit 0 of word_out is 1 when bits 16..1 are sent inverted and 0 when they are sent true.
- R5: When slot_free is 0, the true form of bits 8..1 is the input's bits 8..1.
- R6: When slot_free is 1, the true-form bits 8..1 hold a filler byte. Starting at bit 1 and moving upward, it has a run of L identical bits, where L = min(|RD|, 8) and RD is the running disparity before the word. The run bit is 1 when RD < 0 and 0 otherwise.
- R7: The filler bits above the run alternate. The first bit above the run is the complement of the run bit.
- R8: RD is the sum, over the transmitted words, of (ones minus zeros) across all 18 bits, including bit 17 and bit 0. It is treated as 0 for a word presented with frame_start = 1.
- R9: The true-form disparity D is taken over the 18 bits with bit 0 = 0. The word is inverted exactly when RD is not 0, D is not 0, and D and RD have the same sign. When RD = 0, the word is never inverted.
- R10: Within a frame, the running sum of (ones minus zeros) over the output words never leaves the range -18..+18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | First word of a frame |
| slot_free | input | 1 | Bits 8..1 of this word may be replaced by a filler byte |
| word_in | input | 18 | Word from the frame builder |
| word_out | output | 18 | Encoded word to the serializer |
| out_frame_start | output | 1 | frame_start delayed to line up with word_out |

## Verification
The bench drives several input patterns, and each one separates a different part of the encoder:
- A hand-worked opening sequence pins the filler byte for RD = 0 (pure alternation), the inversion of an all-zero word, and a six-bit zero run.
- All-zero and all-one frames without slots push RD to the edges of its range and exercise inversion in both directions.
- Frames made entirely of free slots exercise the clamp at eight.
- A header-like frame, with slots only near its end, and pseudo-random frames mix every case.
- Two frames that differ only in input bit 0 must encode identically.

A scoreboard model built from the requirements predicts every output word. The monitor also rebuilds the running sum from the output pins.

// File: rtl/pbe_pkg.sv
package pbe_pkg;

   typedef enum logic {
      POL_TRUE = 1'b0,
      POL_INV  = 1'b1
   } pbe_pol_e;

   typedef enum logic {
      CNT_RIPPLE = 1'b0,
      CNT_PAIRED = 1'b1
   } pbe_cnt_e;

endpackage

// File: rtl/pbe_ones_count.sv
module pbe_ones_count #(
   parameter int                W      = 18,
   parameter pbe_pkg::pbe_cnt_e STYLE  = pbe_pkg::CNT_RIPPLE,
   localparam int               CNT_W  = $clog2(W + 1)
) (
   input  logic [W-1:0]     vec,
   output logic [CNT_W-1:0] ones
);

   initial begin
      if (W < 2) $error("pbe_ones_count: W must be at least 2");
   end

   generate
      if (STYLE == pbe_pkg::CNT_RIPPLE) begin : g_ripple
         logic [CNT_W-1:0] acc [0:W];
         assign acc[0] = '0;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign acc[i+1] = acc[i] + CNT_W'(vec[i]);
         end
         assign ones = acc[W];
      end else begin : g_paired
         localparam int NP = (W + 1) / 2;
         logic [1:0]       pair [0:NP-1];
         logic [CNT_W-1:0] acc  [0:NP];
         assign acc[0] = '0;
         for (genvar p = 0; p < NP; p++) begin : g_pair
            if (2*p + 1 < W) begin : g_two
               assign pair[p] = {1'b0, vec[2*p]} + {1'b0, vec[2*p+1]};
            end else begin : g_one
               assign pair[p] = {1'b0, vec[2*p]};
            end
            assign acc[p+1] = acc[p] + CNT_W'(pair[p]);
         end
         assign ones = acc[NP];
      end
   endgenerate

endmodule

// File: rtl/pbe_fill_gen.sv
module pbe_fill_gen #(
   parameter int SLOT_W = 8,
   parameter int RD_W   = 7
) (
   input  logic signed [RD_W-1:0] rd,
   output logic [SLOT_W-1:0]      fill
);

   initial begin
      if (SLOT_W < 1)  $error("pbe_fill_gen: SLOT_W must be positive");
      if (RD_W < 3)    $error("pbe_fill_gen: RD_W too narrow");
   end

   logic run_bit;
   int   run_len;
   int   mag;

   always_comb begin
      run_bit = rd[RD_W-1];
      mag     = rd[RD_W-1] ? -int'(rd) : int'(rd);
      run_len = (mag > SLOT_W) ? SLOT_W : mag;
   end

   generate
      for (genvar j = 0; j < SLOT_W; j++) begin : g_fill
         always_comb begin
            if (j < run_len) begin
               fill[j] = run_bit;
            end else if (((j - run_len) % 2) == 0) begin
               fill[j] = ~run_bit;
            end else begin
               fill[j] = run_bit;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/pbe_pol_decide.sv
module pbe_pol_decide #(
   parameter int RD_W = 7
) (
   input  logic signed [RD_W-1:0] rd,
   input  logic signed [RD_W-1:0] d_true,
   output pbe_pkg::pbe_pol_e      pol
);

   logic same_sign;

   always_comb begin
      same_sign = (rd[RD_W-1] == d_true[RD_W-1]);
      if ((rd != '0) && (d_true != '0) && same_sign) begin
         pol = pbe_pkg::POL_INV;
      end else begin
         pol = pbe_pkg::POL_TRUE;
      end
   end

endmodule

// File: rtl/pbe_encoder.sv
module pbe_encoder #(
   parameter int                WORD_W    = 18,
   parameter int                SLOT_LO   = 1,
   parameter int                SLOT_W    = 8,
   parameter pbe_pkg::pbe_cnt_e CNT_STYLE = pbe_pkg::CNT_RIPPLE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              slot_free,
   input  logic [WORD_W-1:0] word_in,
   output logic [WORD_W-1:0] word_out,
   output logic              out_frame_start
);

   localparam int CNT_W = $clog2(WORD_W + 1);
   localparam int RD_W  = $clog2(2*WORD_W + 1) + 1;
   localparam int GUARD = WORD_W - 1;
   localparam logic signed [RD_W-1:0] WORD_S = RD_W'(WORD_W);

   initial begin
      if (WORD_W < 4)                   $error("pbe_encoder: WORD_W too small");
      if (SLOT_LO < 1)                  $error("pbe_encoder: slot overlaps polarity bit");
      if (SLOT_LO + SLOT_W > WORD_W - 1) $error("pbe_encoder: slot overlaps guard bit");
   end

   logic signed [RD_W-1:0] rd_q;
   logic signed [RD_W-1:0] rd_eff;
   logic signed [RD_W-1:0] d_true;
   logic signed [RD_W-1:0] d_tx;
   logic signed [RD_W-1:0] rd_next;
   logic [SLOT_W-1:0]      fill;
   logic [WORD_W-1:0]      w_true;
   logic [WORD_W-1:0]      w_tx;
   logic [CNT_W-1:0]       ones_true;
   logic [CNT_W-1:0]       ones_tx;
   pbe_pkg::pbe_pol_e      pol;

   // running disparity seen by this word
   always_comb begin
      rd_eff = frame_start ? '0 : rd_q;
   end

   pbe_fill_gen #(
      .SLOT_W (SLOT_W),
      .RD_W   (RD_W)
   ) u_fill (
      .rd   (rd_eff),
      .fill (fill)
   );

   // true-form word: polarity bit cleared, slot optionally replaced
   always_comb begin
      w_true    = word_in;
      w_true[0] = 1'b0;
      if (slot_free) begin
         w_true[SLOT_LO +: SLOT_W] = fill;
      end
   end

   pbe_ones_count #(
      .W     (WORD_W),
      .STYLE (CNT_STYLE)
   ) u_cnt_true (
      .vec  (w_true),
      .ones (ones_true)
   );

   always_comb begin
      d_true = ($signed(RD_W'(ones_true)) <<< 1) - WORD_S;
   end

   pbe_pol_decide #(
      .RD_W (RD_W)
   ) u_pol (
      .rd     (rd_eff),
      .d_true (d_true),
      .pol    (pol)
   );

   always_comb begin
      if (pol == pbe_pkg::POL_INV) begin
         w_tx = {w_true[GUARD], ~w_true[GUARD-1:1], 1'b1};
      end else begin
         w_tx = w_true;
      end
   end

   pbe_ones_count #(
      .W     (WORD_W),
      .STYLE (CNT_STYLE)
   ) u_cnt_tx (
      .vec  (w_tx),
      .ones (ones_tx)
   );

   always_comb begin
      d_tx    = ($signed(RD_W'(ones_tx)) <<< 1) - WORD_S;
      rd_next = rd_eff + d_tx;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_out        <= '0;
         out_frame_start <= 1'b0;
         rd_q            <= '0;
      end else begin
         word_out        <= w_tx;
         out_frame_start <= frame_start;
         rd_q            <= rd_next;
      end
   end

   // R2: marker follows its word by one clock
   a_r2_marker_latency: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (out_frame_start == $past(frame_start)));

   // R3: guard bit passes unchanged
   a_r3_guard_bit: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (word_out[GUARD] == $past(word_in[GUARD])));

   // R4: true-form word keeps the bits above the slot
   a_r4_true_upper: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !word_out[0]) |->
         (word_out[GUARD-1:SLOT_LO+SLOT_W] == $past(word_in[GUARD-1:SLOT_LO+SLOT_W])));

   // R4: inverted word complements the bits above the slot
   a_r4_inv_upper: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && word_out[0]) |->
         (word_out[GUARD-1:SLOT_LO+SLOT_W] == ~$past(word_in[GUARD-1:SLOT_LO+SLOT_W])));

   // R5: without a free slot the payload follows the input
   a_r5_slot_kept: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(slot_free)) |->
         (word_out[SLOT_LO +: SLOT_W] ==
          ($past(word_in[SLOT_LO +: SLOT_W]) ^ {SLOT_W{word_out[0]}})));

   // R10: running disparity stays inside one word's worth
   a_r10_rd_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_q <= WORD_S) && (rd_q >= -WORD_S));

endmodule

// File: tb/test_pbe_encoder.sv
module test_pbe_encoder;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        frame_start;
   logic        slot_free;
   logic [17:0] word_in;
   logic [17:0] word_out;
   logic        out_frame_start;

   always #4 clk = ~clk;

   pbe_encoder i_pbe_encoder (
      .clk             (clk),
      .rst_n           (rst_n),
      .frame_start     (frame_start),
      .slot_free       (slot_free),
      .word_in         (word_in),
      .word_out        (word_out),
      .out_frame_start (out_frame_start)
   );

   typedef struct {
      logic [17:0] w;
      logic        fs;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   errors = 0;
   int   rd_m   = 0;
   int   obs_rd = 0;
   bit   done   = 0;

   function automatic logic [17:0] model_word(input logic [17:0] w, input logic free,
                                              input logic fs);
      logic [17:0] t;
      int          rd;
      int          len;
      int          d;
      logic        run;
      rd   = fs ? 0 : rd_m;
      t    = w;
      t[0] = 1'b0;
      if (free) begin
         run = (rd < 0);
         len = (rd < 0) ? -rd : rd;
         if (len > 8) len = 8;
         for (int k = 1; k <= 8; k++) begin
            if (k <= len)                t[k] = run;
            else if (((k - len) % 2) == 1) t[k] = ~run;
            else                         t[k] = run;
         end
      end
      d = 2*$countones(t) - 18;
      if (rd != 0 && d != 0 && ((rd > 0) == (d > 0))) begin
         t = {t[17], ~t[16:1], 1'b1};
      end
      rd_m = rd + 2*$countones(t) - 18;
      return t;
   endfunction

   task automatic drive(input logic [17:0] w, input logic free, input logic fs,
                        input string tag);
      exp_t e;
      @(negedge clk);
      word_in     = w;
      slot_free   = free;
      frame_start = fs;
      e.w   = model_word(w, free, fs);
      e.fs  = fs;
      e.tag = tag;
      q.push_back(e);
   endtask

   task automatic drive_hand(input logic [17:0] w, input logic free, input logic fs,
                             input logic [17:0] exp_w, input string tag);
      exp_t        e;
      logic [17:0] unused;
      @(negedge clk);
      word_in     = w;
      slot_free   = free;
      frame_start = fs;
      unused = model_word(w, free, fs);
      e.w   = exp_w;
      e.fs  = fs;
      e.tag = tag;
      q.push_back(e);
   endtask

   // monitor: compare after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (word_out !== e.w || out_frame_start !== e.fs) begin
               errors++;
               $display("FAIL %s: word_out=%05h fs=%0b expected %05h fs=%0b",
                        e.tag, word_out, out_frame_start, e.w, e.fs);
            end
            if (out_frame_start) obs_rd = 0;
            obs_rd += 2*$countones(word_out) - 18;
            checks++;
            if (obs_rd > 18 || obs_rd < -18) begin
               errors++;
               $display("FAIL R10: running sum %0d expected within -18..18", obs_rd);
            end
         end
      end
   end

   initial begin
      #(8*200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   logic [17:0] lfsr = 18'h2A5C3;

   function automatic logic [17:0] step(input logic [17:0] s);
      return {s[16:0], s[17] ^ s[10]};
   endfunction

   initial begin
      rst_n       = 1'b0;
      frame_start = 1'b1;
      slot_free   = 1'b1;
      word_in     = 18'h3FFFF;
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if (word_out !== 18'h0 || out_frame_start !== 1'b0) begin
         errors++;
         $display("FAIL R1: word_out=%05h fs=%0b expected 00000 fs=0",
                  word_out, out_frame_start);
      end
      rst_n = 1'b1;

      // hand-worked opening: R6 R7 R8 R9
      drive_hand(18'h00000, 1'b1, 1'b1, 18'h000AA, "R7 alternate fill at zero RD");
      drive_hand(18'h00000, 1'b0, 1'b0, 18'h1FFFF, "R9 invert same sign");
      drive_hand(18'h00000, 1'b1, 1'b0, 18'h00080, "R6 six-bit zero run");
      for (int i = 3; i < 20; i++) drive(18'h00000, 1'b0, 1'b0, "R8 zero frame");

      // all-ones frame, no slots: R3 R5 R9
      for (int i = 0; i < 20; i++) drive(18'h3FFFF, 1'b0, i == 0, "R5 ones frame");

      // every slot free: R6 clamp
      for (int i = 0; i < 20; i++) drive(18'h3FE01, 1'b1, i == 0, "R6 all slots");

      // R4: polarity input bit ignored
      drive(18'h15A6C, 1'b0, 1'b1, "R4 bit0 clear");
      drive(18'h15A6D, 1'b0, 1'b1, "R4 bit0 set");

      // header-like frame, slots near the end: R2 R3
      for (int i = 0; i < 20; i++) begin
         logic [17:0] w;
         w = {1'b0, 3'b101, (i < 14), 4'(i), 8'(i*37), 1'b0};
         drive(w, (i >= 14), i == 0, "R2 header frame");
      end

      // pseudo-random frames: R8 R9
      for (int f = 0; f < 6; f++) begin
         for (int i = 0; i < 20; i++) begin
            lfsr = step(step(step(lfsr)));
            drive(lfsr, lfsr[5] ^ lfsr[12], i == 0, "R9 random frame");
         end
      end

      // mid-frame restart: R8 clear on frame_start
      drive(18'h00000, 1'b0, 1'b0, "R8 before restart");
      drive_hand(18'h00000, 1'b1, 1'b1, 18'h000AA, "R8 restart clears RD");

      @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule